// File: doc/BRIEF.md
# Four-Slot Module Interrupt Status Hub

This block gathers the condition of four peripheral module slots, named A to D, into one 16-bit status word. It also raises a single interrupt line that the host shares among all slots. Each slot provides four inputs: an active-low error line, two active-low interrupt request lines (request 0 and request 1), and a one-cycle timeout pulse from the access controller. The host reads and writes the status word and four slot configuration words through a plain register port.

The host sets each request line to level sensing or edge sensing. A level-sensed request bit shows the synchronized line as it is now. An edge-sensed request bit captures the falling edge of the line and holds it until the host writes a one to that bit. Timeout flags hold until the host writes a one to clear them. Error flags show the live line and cannot be written. The shared interrupt is the OR of every request bit, of every timeout flag whose slot has timeout interrupts enabled, and of every error flag whose slot has error interrupts enabled.

Top module: `slot_irq_hub`

## Requirements
- R1: After reset, the status word reads 0x0000, every configuration word reads 0x0000, and `irqOut` is 0.
- R2: A timeout pulse on slot s sets status bit 12+s, so bits 15..12 are slots D, C, B, A. The flag stays set until it is cleared.
- R3: Writing status (address 0) with a 1 in bit 12+s clears that timeout flag. A 0 in that bit leaves the flag as it is.
- R4: Status bit 8+s is 1 while `errN[s]` is low. Writes to bits 11..8 change nothing.
- R5: With level sensing, status bit 2s (request 0) and bit 2s+1 (request 1) equal the inverted synchronized request line, and writes to those bits change nothing.
- R6: With edge sensing, a falling edge on the request line sets its status bit. The bit stays set after the line returns high and is cleared only by writing a 1 to it.
- R7: If a new event (a timeout pulse or a detected edge) arrives in the same cycle as a clear write to its bit, the bit ends up set.
- R8: The configuration word for slot s is at address s+1. Bit 5 selects request 1 sensing and bit 4 selects request 0 sensing (0 means level, 1 means edge). Bit 3 enables error interrupts and bit 2 enables timeout interrupts. All other bits, and addresses 5 to 7, read as 0.
- R9: One clock after the status word changes, `irqOut` becomes the OR of all request bits, of each timeout flag whose slot has bit 2 set, and of each error flag whose slot has bit 3 set.
- R10: A change on an error or request line passes through two synchronizing flops. A level-sensed bit shows the change after the second rising edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 3 | Register select: 0 for status, 1 to 4 for slot A to D configuration |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Read data for the addressed register (combinational) |
| errN | input | 4 | Active-low error line of each slot |
| irq0N | input | 4 | Active-low request 0 line of each slot |
| irq1N | input | 4 | Active-low request 1 line of each slot |
| timeoutPulse | input | 4 | One-cycle timeout event of each slot |
| irqOut | output | 1 | Shared interrupt output |

## Verification
The hardest case to produce is the collision, where an edge-sensed request is detected on the same rising edge at which the host's clear write lands. The bench first latches the bit with an earlier edge. It then pulls the line low again and counts exactly two rising edges through the synchronizer. Only then does it issue the clear write, so that the write and the detected edge fall on the third rising edge together. The same collision is set up for timeout flags by driving the pulse and the clear write in the same cycle. Sync latency is checked one edge at a time, so that a synchronizer with a missing flop is caught.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
  localparam int SLOTS   = 4;
  localparam int REQ_W   = 2 * SLOTS;
  localparam int STAT_W  = 4 * SLOTS;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int CFG_W   = 4;
  localparam int CFG_LSB = 2;
  // positions inside the stored configuration field
  localparam int CFG_TO_EN  = 0;
  localparam int CFG_ERR_EN = 1;
  localparam int CFG_EDGE0  = 2;
  localparam int CFG_EDGE1  = 3;
  // status word field bases
  localparam int ERR_LSB = REQ_W;
  localparam int TO_LSB  = REQ_W + SLOTS;

  typedef struct packed {
    logic [SLOTS-1:0] clrTo;
    logic [REQ_W-1:0] clrReq;
    logic [SLOTS-1:0] cfgWe;
    logic [CFG_W-1:0] cfgVal;
    logic [SLOTS:0]   rdSel;
  } hubStrobe_t;
endpackage

// File: rtl/irqhub_sync.sv
module irqhub_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= {WIDTH{RST_VAL}};
        else       stageQ[g] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= {WIDTH{RST_VAL}};
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/irqhub_ctrl.sv
module irqhub_ctrl
  import irqhub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output hubStrobe_t        strobe
);
  // error field of a status write is read-only and deliberately dropped
  logic unusedErrBits;
  assign unusedErrBits = ^hostWrData[ERR_LSB +: SLOTS];

  always_comb begin
    strobe        = '0;
    strobe.cfgVal = hostWrData[CFG_LSB +: CFG_W];
    for (int s = 0; s <= SLOTS; s++) begin
      if (hostAddr == ADDR_W'(s)) strobe.rdSel[s] = 1'b1;
    end
    if (hostWrEn) begin
      if (hostAddr == '0) begin
        strobe.clrTo  = hostWrData[TO_LSB +: SLOTS];
        strobe.clrReq = hostWrData[REQ_W-1:0];
      end
      for (int s = 0; s < SLOTS; s++) begin
        if (hostAddr == ADDR_W'(s + 1)) strobe.cfgWe[s] = 1'b1;
      end
    end
  end

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrEn |-> (strobe.clrTo == '0 && strobe.clrReq == '0 && strobe.cfgWe == '0)); // R3
  AST_ONE_READ_SEL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.rdSel)); // R8
endmodule

// File: rtl/irqhub_datapath.sv
module irqhub_datapath
  import irqhub_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hubStrobe_t        strobe,
  input  logic [SLOTS-1:0]  errN,
  input  logic [SLOTS-1:0]  irq0N,
  input  logic [SLOTS-1:0]  irq1N,
  input  logic [SLOTS-1:0]  timeoutPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int SYNC_W = 3 * SLOTS;

  logic [SYNC_W-1:0] syncIn, syncOut;
  logic [SLOTS-1:0]  errSyncN, irq0SyncN, irq1SyncN;
  logic [REQ_W-1:0]  reqSyncN, reqPrevN, edgeHit, edgeMode, latchQ, reqStat;
  logic [CFG_W-1:0]  cfgQ [SLOTS];
  logic [SLOTS-1:0]  toQ, toEn, errEn, errStat;
  logic [STAT_W-1:0] statusWord;
  logic              irqNext;

  assign syncIn = {irq1N, irq0N, errN};

  irqhub_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (syncIn),
    .syncOut (syncOut)
  );

  assign errSyncN  = syncOut[0 +: SLOTS];
  assign irq0SyncN = syncOut[SLOTS +: SLOTS];
  assign irq1SyncN = syncOut[2*SLOTS +: SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign reqSyncN[2*s]     = irq0SyncN[s];
    assign reqSyncN[2*s + 1] = irq1SyncN[s];
    assign edgeMode[2*s]     = cfgQ[s][CFG_EDGE0];
    assign edgeMode[2*s + 1] = cfgQ[s][CFG_EDGE1];
    assign toEn[s]           = cfgQ[s][CFG_TO_EN];
    assign errEn[s]          = cfgQ[s][CFG_ERR_EN];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cfgQ[s] <= '0;
      else if (strobe.cfgWe[s]) cfgQ[s] <= strobe.cfgVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) toQ[s] <= 1'b0;
      else       toQ[s] <= timeoutPulse[s] | (toQ[s] & ~strobe.clrTo[s]);
    end

    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      toQ[s] && !strobe.clrTo[s] |=> toQ[s]); // R2
    AST_TO_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
      timeoutPulse[s] |=> toQ[s]); // R7
  end

  assign errStat = ~errSyncN;

  // falling edge of the synchronized active-low request line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPrevN <= '1;
    else       reqPrevN <= reqSyncN;
  end
  assign edgeHit = reqPrevN & ~reqSyncN;

  for (genvar k = 0; k < REQ_W; k++) begin : g_req
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            latchQ[k] <= 1'b0;
      else if (edgeMode[k]) latchQ[k] <= edgeHit[k] | (latchQ[k] & ~strobe.clrReq[k]);
      else                  latchQ[k] <= 1'b0;
    end
    assign reqStat[k] = edgeMode[k] ? latchQ[k] : ~reqSyncN[k];

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
      !edgeMode[k] |=> !latchQ[k]); // R5
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      edgeMode[k] && latchQ[k] && !strobe.clrReq[k] |=> latchQ[k]); // R6
    AST_EDGE_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
      edgeMode[k] && edgeHit[k] |=> latchQ[k]); // R7
  end

  assign statusWord = {toQ, errStat, reqStat};

  always_comb begin
    rdData = '0;
    if (strobe.rdSel[0]) rdData = statusWord;
    for (int s = 0; s < SLOTS; s++) begin
      if (strobe.rdSel[s+1]) rdData[CFG_LSB +: CFG_W] = cfgQ[s];
    end
  end

  assign irqNext = (|reqStat) | (|(toQ & toEn)) | (|(errStat & errEn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= irqNext;
  end

  AST_REQ_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (reqStat != '0) |=> irqOut); // R9
  AST_GATED_TO_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ((toQ & toEn) != '0) |=> irqOut); // R9
endmodule

// File: rtl/slot_irq_hub.sv
module slot_irq_hub
  import irqhub_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [SLOTS-1:0]  errN,
  input  logic [SLOTS-1:0]  irq0N,
  input  logic [SLOTS-1:0]  irq1N,
  input  logic [SLOTS-1:0]  timeoutPulse,
  output logic              irqOut
);
  hubStrobe_t strobe;

  irqhub_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .strobe     (strobe)
  );

  irqhub_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .errN         (errN),
    .irq0N        (irq0N),
    .irq1N        (irq1N),
    .timeoutPulse (timeoutPulse),
    .rdData       (hostRdData),
    .irqOut       (irqOut)
  );
endmodule

// File: tb/sim_slot_irq_hub.sv
module sim_slot_irq_hub;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic [3:0]  errN = '1, irq0N = '1, irq1N = '1, timeoutPulse = '0;
  logic        irqOut;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  slot_irq_hub u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .errN(errN),
    .irq0N(irq0N), .irq1N(irq1N), .timeoutPulse(timeoutPulse), .irqOut(irqOut)
  );

  // vectors: {errN, irq1N, irq0N}, all slots in level mode
  localparam logic [11:0] VEC [8] = '{
    12'hFFF, 12'hFFE, 12'hF7F, 12'hEFF, 12'h5A5, 12'h0F0, 12'hF0F, 12'h000
  };

  function automatic logic [15:0] expStat(logic [11:0] v);
    logic [15:0] r = '0;
    for (int s = 0; s < 4; s++) begin
      r[8+s]   = ~v[8+s];
      r[2*s]   = ~v[s];
      r[2*s+1] = ~v[4+s];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(posedge clk); @(negedge clk);
    hostWrEn = 1'b0; hostWrData = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    rd(0, d); check("R1 status", d, 16'h0000);
    rd(1, d); check("R1 cfg A", d, 16'h0000);
    check("R1 irqOut", {15'd0, irqOut}, 16'h0000);

    // R4 R5 R9 table walk, level mode
    foreach (VEC[i]) begin
      {errN, irq1N, irq0N} = VEC[i];
      tick(3);
      rd(0, d); check("R4 R5 vector status", d, expStat(VEC[i]));
      check("R9 vector irqOut", {15'd0, irqOut}, {15'd0, |expStat(VEC[i])[7:0]});
    end

    // R4 R5 writes ignored on error and level bits (last vector all asserted)
    wr(0, 16'hFFFF);
    rd(0, d); check("R4 R5 write ignored", d, 16'h0FFF);
    {errN, irq1N, irq0N} = 12'hFFF;
    tick(3);

    // R8 configuration map
    wr(2, 16'hFFFF);
    rd(2, d); check("R8 cfg B mask", d, 16'h003C);
    rd(7, d); check("R8 unmapped", d, 16'h0000);
    wr(2, 16'h0000);

    // R2 R3 R9 timeout slot C
    timeoutPulse[2] = 1'b1; tick(1); timeoutPulse[2] = 1'b0;
    rd(0, d); check("R2 timeout C bit14", d, 16'h4000);
    tick(1); check("R9 timeout gated off", {15'd0, irqOut}, 16'h0000);
    wr(3, 16'h0004); tick(1);
    check("R9 timeout enabled", {15'd0, irqOut}, 16'h0001);
    wr(0, 16'h0000);
    rd(0, d); check("R3 zero write keeps", d, 16'h4000);
    wr(0, 16'h4000);
    rd(0, d); check("R3 one write clears", d, 16'h0000);
    tick(1); check("R9 irq drops", {15'd0, irqOut}, 16'h0000);
    wr(3, 16'h0000);

    // R7 timeout and clear same cycle, slot A
    timeoutPulse[0] = 1'b1;
    wr(0, 16'h1000);
    timeoutPulse[0] = 1'b0;
    rd(0, d); check("R7 timeout race", d, 16'h1000);
    wr(0, 16'h1000);

    // R10 sync latency, slot A request 0 level
    irq0N[0] = 1'b0;
    tick(1); rd(0, d); check("R10 after one edge", d, 16'h0000);
    tick(1); rd(0, d); check("R10 after two edges", d, 16'h0001);
    check("R10 irq not yet", {15'd0, irqOut}, 16'h0000);
    tick(1); check("R9 irq follows", {15'd0, irqOut}, 16'h0001);
    irq0N[0] = 1'b1; tick(3);

    // R6 edge mode slot D request 1 (bit 7)
    wr(4, 16'h0020);
    irq1N[3] = 1'b0; tick(1); irq1N[3] = 1'b1; tick(5);
    rd(0, d); check("R6 edge latched", d, 16'h0080);
    wr(0, 16'h0000);
    rd(0, d); check("R6 zero write keeps", d, 16'h0080);
    wr(0, 16'h0080);
    rd(0, d); check("R6 one write clears", d, 16'h0000);

    // R7 edge and clear same edge
    irq1N[3] = 1'b0; tick(1); irq1N[3] = 1'b1; tick(5);
    irq1N[3] = 1'b0; tick(2);
    irq1N[3] = 1'b1;
    wr(0, 16'h0080);
    tick(3);
    rd(0, d); check("R7 edge race", d, 16'h0080);
    wr(0, 16'h0080);
    wr(4, 16'h0000);

    // R4 R9 error gating slot B
    errN[1] = 1'b0; tick(3);
    rd(0, d); check("R4 error B bit9", d, 16'h0200);
    check("R9 error gated off", {15'd0, irqOut}, 16'h0000);
    wr(2, 16'h0008); tick(1);
    check("R9 error enabled", {15'd0, irqOut}, 16'h0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule